// File: doc/BRIEF.md
# Head Select Decode and Unsafe-Status Driver

This block turns a 4-bit head number and a 2-bit servo group code into one enable per head. It also drives a shared "head unsafe" status line through an active-low pull-down, so the line can be wired together across several amplifier dies.

The meaning and polarity of the status change with the operating state:

- In sleep and standby the line is released.
- In servo-write operation the line is pulled low.
- In the analog test modes the line is released. In the thermal-asperity test the line is pulled low while an asperity is reported.
- In normal read or write the line flags digital fault inputs. Read flags a fault by pulling low. Write flags a fault by releasing the line.

A configuration mask bit replaces fault reporting with a fixed level in each direction. The unsafe indication stays on for a fixed hold time after the last fault clears. When the part switches into write, a blanking window holds the line low during the switching transient. A low-supply fault also raises a write-current inhibit output unless the inhibit has been disabled.

All control and status pins are plain levels sampled on the system clock. There is no data stream, so there is no valid/ready handshake and no back-pressure. The status and inhibit outputs are registered: each reflects the inputs present before the clock edge at which it updates. The head enables are combinational.

Top module: `head_safety`

## Requirements
- R1: With power code 2'b11 (active) and servo group 2'b00, a head code of 0 to 9 enables exactly the matching bit of `head_en` and no other bit.
- R2: A head code of 10 to 15 is an invalid-head fault. In read (`rw_n`=1) it enables head 0 only. In write (`rw_n`=0) it enables no head.
- R3: Servo group 2'b11 enables all ten heads. 2'b01 enables the odd heads (10'h2AA). 2'b10 enables the even heads (10'h155). With any power code other than 2'b11, `head_en` is all zero.
- R4: With power code 2'b00 (sleep) or 2'b01/2'b10 (standby), `unsafe_pull` is 0 (released), whatever the fault inputs are. This is also the value after reset.
- R5: While active with a nonzero servo group, `unsafe_pull` is 1.
- R6: In write with `cfg_mask`=0 and outside the blanking window, `unsafe_pull` is 0 while a write fault (invalid head, reference pin, low supply, head open/short, slow write data) is present or held, and 1 otherwise. With `cfg_mask`=1 it is 1.
- R7: In read with `cfg_mask`=0, `unsafe_pull` is 1 while a read fault (invalid head, reference pin, low supply) is present or held, and 0 otherwise. The head open/short and slow-write-data inputs are ignored in read. With `cfg_mask`=1 it is 0.
- R8: While active with servo group 2'b00 and test code 3'b001 to 3'b011, `unsafe_pull` is 0. With test code 3'b1xx it is 1 exactly while `flt_asperity` is 1.
- R9: After the last fault clears, the unsafe indication persists for HOLD_CYC = CLK_MHZ*HOLD_NS/1000 clocks. With the defaults this is 150 clocks, or 0.75 µs.
- R10: A falling edge of `rw_n` starts a blanking window of BLANK_CYC clocks (default 32). During the window `unsafe_pull` is 1 and write faults are not detected.
- R11: One clock after `flt_low_supply`=1 with `cfg_inh_off`=0, `wr_inhibit` is 1. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rw_n | input | 1 | 1 = read, 0 = write |
| pwr_mode | input | 2 | 00 sleep, 01/10 standby, 11 active |
| head_code | input | 4 | Selected head number |
| servo_grp | input | 2 | 00 single, 01 odd, 10 even, 11 all |
| test_sel | input | 3 | 000 none, 001..011 analog tests, 1xx asperity test |
| cfg_mask | input | 1 | Replace fault reporting with a fixed level |
| cfg_inh_off | input | 1 | Disable write-current inhibit on low supply |
| flt_low_supply | input | 1 | Low supply fault |
| flt_ref_pin | input | 1 | Reference resistor pin fault |
| flt_wr_head | input | 1 | Write head open or shorted |
| flt_wd_slow | input | 1 | Write data frequency too low |
| flt_asperity | input | 1 | Thermal asperity detected |
| head_en | output | N_HEADS | One enable per head |
| unsafe_pull | output | 1 | 1 = pull status line low, 0 = release |
| wr_inhibit | output | 1 | Write-current inhibit |

## Verification
The assertions check these every cycle:

- the one-hot head enables in single-head selection;
- the released line outside active;
- the pulled line in servo operation and on the first write-entry edge;
- the masked read level;
- the read fault response;
- the inhibit timing;
- the hold counter's range and reload.

Some behaviour only the bench scenarios can show, because it depends on long runs of cycles:

- the 150-clock hold, checked both partway through and after it has run out;
- the blanking window giving way to fault reporting in write;
- the way an invalid head code behaves differently in read and in write;
- the write-only faults being ignored in read.

// File: rtl/hsafe_pkg.sv
`timescale 1ns/1ps
package hsafe_pkg;
  typedef enum logic [1:0] {
    PWR_SLEEP  = 2'b00,
    PWR_STBY_A = 2'b01,
    PWR_STBY_B = 2'b10,
    PWR_ACTIVE = 2'b11
  } pwr_e;

  typedef enum logic [1:0] {
    GRP_ONE  = 2'b00,
    GRP_ODD  = 2'b01,
    GRP_EVEN = 2'b10,
    GRP_ALL  = 2'b11
  } grp_e;
endpackage

// File: rtl/hs_head_decode.sv
`timescale 1ns/1ps
module hs_head_decode
  import hsafe_pkg::*;
#(
  parameter int N_HEADS = 10,
  parameter int CODE_W  = 4
) (
  input  logic [CODE_W-1:0]  code,
  input  logic [1:0]         grp,
  input  logic               rd_mode,
  input  logic               active,
  output logic [N_HEADS-1:0] en,
  output logic               invalid
);
  // codes at or above the head count are out of range
  assign invalid = (code >= CODE_W'(N_HEADS));

  for (genvar i = 0; i < N_HEADS; i++) begin : g_head
    localparam bit IS_ODD = (i % 2) == 1;
    logic hit;
    // read falls back to head 0 on an invalid code; write selects nothing
    if (i == 0) begin : g_zero
      assign hit = (code == CODE_W'(i)) || (rd_mode && invalid);
    end else begin : g_rest
      assign hit = (code == CODE_W'(i));
    end
    always_comb begin
      unique case (grp_e'(grp))
        GRP_ALL:  en[i] = active;
        GRP_ODD:  en[i] = active && IS_ODD;
        GRP_EVEN: en[i] = active && !IS_ODD;
        default:  en[i] = active && hit;
      endcase
    end
  end
endmodule

// File: rtl/hs_retrig_timer.sv
`timescale 1ns/1ps
module hs_retrig_timer #(
  parameter int LEN = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic busy
);
  localparam int W = $clog2(LEN + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (trig)       cnt <= W'(LEN);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = trig || (cnt != '0);

  // R9
  timer_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= W'(LEN));
  // R9
  timer_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (cnt == W'(LEN)));
endmodule

// File: rtl/head_safety.sv
`timescale 1ns/1ps
module head_safety
  import hsafe_pkg::*;
#(
  parameter int N_HEADS   = 10,
  parameter int CLK_MHZ   = 200,
  parameter int HOLD_NS   = 750,
  parameter int BLANK_CYC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rw_n,
  input  logic [1:0]         pwr_mode,
  input  logic [3:0]         head_code,
  input  logic [1:0]         servo_grp,
  input  logic [2:0]         test_sel,
  input  logic               cfg_mask,
  input  logic               cfg_inh_off,
  input  logic               flt_low_supply,
  input  logic               flt_ref_pin,
  input  logic               flt_wr_head,
  input  logic               flt_wd_slow,
  input  logic               flt_asperity,
  output logic [N_HEADS-1:0] head_en,
  output logic               unsafe_pull,
  output logic               wr_inhibit
);
  localparam int HOLD_CYC = (CLK_MHZ * HOLD_NS) / 1000;

  logic active, servo_on, test_on, normal;
  logic rw_q, wr_fall, blank_on;
  logic invalid, rd_fault, wr_fault, raw_fault, held;
  logic pull_d;

  assign active   = (pwr_e'(pwr_mode) == PWR_ACTIVE);
  assign servo_on = active && (grp_e'(servo_grp) != GRP_ONE);
  assign test_on  = active && !servo_on && (test_sel != 3'b000);
  assign normal   = active && !servo_on && !test_on;

  hs_head_decode #(.N_HEADS(N_HEADS), .CODE_W(4)) u_dec (
    .code    (head_code),
    .grp     (servo_grp),
    .rd_mode (rw_n),
    .active  (active),
    .en      (head_en),
    .invalid (invalid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rw_q <= 1'b1;
    else        rw_q <= rw_n;
  end
  assign wr_fall = rw_q && !rw_n;

  hs_retrig_timer #(.LEN(BLANK_CYC)) u_blank (
    .clk (clk), .rst_n (rst_n), .trig (wr_fall), .busy (blank_on)
  );

  assign rd_fault  = invalid || flt_low_supply || flt_ref_pin;
  assign wr_fault  = rd_fault || flt_wr_head || flt_wd_slow;
  assign raw_fault = normal && (rw_n ? rd_fault : (wr_fault && !blank_on));

  hs_retrig_timer #(.LEN(HOLD_CYC)) u_hold (
    .clk (clk), .rst_n (rst_n), .trig (raw_fault), .busy (held)
  );

  always_comb begin
    pull_d = 1'b0;
    if (!active)        pull_d = 1'b0;
    else if (servo_on)  pull_d = 1'b1;
    else if (test_on)   pull_d = test_sel[2] && flt_asperity;
    else if (!rw_n) begin
      if (blank_on || cfg_mask) pull_d = 1'b1;
      else                      pull_d = !held;
    end else begin
      pull_d = !cfg_mask && held;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unsafe_pull <= 1'b0;
      wr_inhibit  <= 1'b0;
    end else begin
      unsafe_pull <= pull_d;
      wr_inhibit  <= flt_low_supply && !cfg_inh_off;
    end
  end

  // R1
  en_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && servo_grp == 2'b00) |-> $onehot0(head_en));
  // R4
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !unsafe_pull);
  // R5
  servo_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    servo_on |=> unsafe_pull);
  // R10
  wr_blank_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (normal && wr_fall) |=> unsafe_pull);
  // R7
  rd_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (normal && rw_n && cfg_mask) |=> !unsafe_pull);
  // R7
  rd_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (normal && rw_n && !cfg_mask && rd_fault) |=> unsafe_pull);
  // R11
  inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_low_supply && !cfg_inh_off) |=> wr_inhibit);
endmodule

// File: tb/sim_head_safety.sv
`timescale 1ns/1ps
module sim_head_safety;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, rw_n, cfg_mask, cfg_inh_off;
  logic [1:0] pwr_mode, servo_grp;
  logic [3:0] head_code;
  logic [2:0] test_sel;
  logic flt_low_supply, flt_ref_pin, flt_wr_head, flt_wd_slow, flt_asperity;
  logic [9:0] head_en;
  logic unsafe_pull, wr_inhibit;

  head_safety u0 (
    .clk(clk), .rst_n(rst_n), .rw_n(rw_n), .pwr_mode(pwr_mode),
    .head_code(head_code), .servo_grp(servo_grp), .test_sel(test_sel),
    .cfg_mask(cfg_mask), .cfg_inh_off(cfg_inh_off),
    .flt_low_supply(flt_low_supply), .flt_ref_pin(flt_ref_pin),
    .flt_wr_head(flt_wr_head), .flt_wd_slow(flt_wd_slow),
    .flt_asperity(flt_asperity), .head_en(head_en),
    .unsafe_pull(unsafe_pull), .wr_inhibit(wr_inhibit)
  );

  typedef struct packed {
    logic       drv;
    logic [9:0] en;
    logic       inh;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];
  event  pushed;
  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input logic drv, input logic [9:0] en,
                            input logic inh, input string tag);
    exp_t e;
    e.drv = drv; e.en = en; e.inh = inh;
    expq.push_back(e);
    tagq.push_back(tag);
    -> pushed;
    #0.1;
  endtask

  // monitor: pops expected items and compares with the outputs
  initial begin
    forever begin
      @(pushed);
      while (expq.size() > 0) begin
        exp_t  e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        checks++;
        if (unsafe_pull !== e.drv || head_en !== e.en || wr_inhibit !== e.inh) begin
          failures++;
          $display("FAIL %s: actual pull=%0b en=%03h inh=%0b expected pull=%0b en=%03h inh=%0b",
                   t, unsafe_pull, head_en, wr_inhibit, e.drv, e.en, e.inh);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rw_n = 1'b1; pwr_mode = 2'b00; head_code = 4'd0;
    servo_grp = 2'b00; test_sel = 3'b000; cfg_mask = 1'b0; cfg_inh_off = 1'b0;
    flt_low_supply = 1'b0; flt_ref_pin = 1'b0; flt_wr_head = 1'b0;
    flt_wd_slow = 1'b0; flt_asperity = 1'b0;
    step(4);
    rst_n = 1'b1;
    step(1);
    expect_out(1'b0, 10'h000, 1'b0, "R4 reset state");

    // sleep and standby with faults present
    flt_ref_pin = 1'b1; head_code = 4'd13;
    step(3);
    expect_out(1'b0, 10'h000, 1'b0, "R4 sleep with faults");
    pwr_mode = 2'b10;
    step(3);
    expect_out(1'b0, 10'h000, 1'b0, "R3 R4 standby released, no enables");
    flt_ref_pin = 1'b0; head_code = 4'd3;

    // active read
    pwr_mode = 2'b11;
    step(3);
    expect_out(1'b0, 10'h008, 1'b0, "R1 read head 3");
    head_code = 4'd9;
    step(2);
    expect_out(1'b0, 10'h200, 1'b0, "R1 read head 9");
    head_code = 4'd12;
    step(2);
    expect_out(1'b1, 10'h001, 1'b0, "R2 R7 invalid head in read");
    head_code = 4'd3;
    step(90);
    expect_out(1'b1, 10'h008, 1'b0, "R9 still held after 90 clocks");
    step(130);
    expect_out(1'b0, 10'h008, 1'b0, "R9 released after hold");

    flt_ref_pin = 1'b1;
    step(2);
    expect_out(1'b1, 10'h008, 1'b0, "R7 reference fault in read");
    flt_ref_pin = 1'b0;
    step(220);
    expect_out(1'b0, 10'h008, 1'b0, "R7 R9 read clear after hold");

    flt_wr_head = 1'b1; flt_wd_slow = 1'b1;
    step(3);
    expect_out(1'b0, 10'h008, 1'b0, "R7 write-only faults ignored in read");
    flt_wr_head = 1'b0; flt_wd_slow = 1'b0;

    cfg_mask = 1'b1; flt_low_supply = 1'b1;
    step(3);
    expect_out(1'b0, 10'h008, 1'b1, "R7 R11 masked read with low supply");
    cfg_inh_off = 1'b1;
    step(2);
    expect_out(1'b0, 10'h008, 1'b0, "R11 inhibit disabled");
    flt_low_supply = 1'b0; cfg_inh_off = 1'b0; cfg_mask = 1'b0;
    step(220);
    expect_out(1'b0, 10'h008, 1'b0, "R7 read idle");

    // servo groups
    servo_grp = 2'b11;
    step(2);
    expect_out(1'b1, 10'h3FF, 1'b0, "R3 R5 servo all heads");
    servo_grp = 2'b01;
    step(2);
    expect_out(1'b1, 10'h2AA, 1'b0, "R3 R5 servo odd heads");
    servo_grp = 2'b10;
    step(2);
    expect_out(1'b1, 10'h155, 1'b0, "R3 R5 servo even heads");
    servo_grp = 2'b00;

    // test modes
    test_sel = 3'b001;
    step(2);
    expect_out(1'b0, 10'h008, 1'b0, "R8 analog test released");
    test_sel = 3'b011; flt_ref_pin = 1'b1;
    step(2);
    expect_out(1'b0, 10'h008, 1'b0, "R8 analog test ignores faults");
    flt_ref_pin = 1'b0; test_sel = 3'b100;
    step(2);
    expect_out(1'b0, 10'h008, 1'b0, "R8 asperity test idle");
    flt_asperity = 1'b1;
    step(2);
    expect_out(1'b1, 10'h008, 1'b0, "R8 asperity detected");
    flt_asperity = 1'b0;
    step(2);
    expect_out(1'b0, 10'h008, 1'b0, "R8 asperity cleared");
    test_sel = 3'b000;
    step(2);

    // write entry
    rw_n = 1'b0; flt_wd_slow = 1'b1;
    step(5);
    expect_out(1'b1, 10'h008, 1'b0, "R10 blanked after write entry");
    step(40);
    expect_out(1'b0, 10'h008, 1'b0, "R6 write fault after blanking");
    flt_wd_slow = 1'b0;
    step(220);
    expect_out(1'b1, 10'h008, 1'b0, "R6 write no fault");
    cfg_mask = 1'b1; flt_wr_head = 1'b1;
    step(2);
    expect_out(1'b1, 10'h008, 1'b0, "R6 write masked");
    flt_wr_head = 1'b0; cfg_mask = 1'b0; head_code = 4'd11;
    step(2);
    expect_out(1'b0, 10'h000, 1'b0, "R2 R6 invalid head in write");
    head_code = 4'd3;
    step(220);
    expect_out(1'b1, 10'h008, 1'b0, "R6 write clear after hold");

    rw_n = 1'b1;
    step(2);
    expect_out(1'b0, 10'h008, 1'b0, "R7 back to read");
    pwr_mode = 2'b00; flt_low_supply = 1'b1;
    step(2);
    expect_out(1'b0, 10'h000, 1'b1, "R4 R11 sleep with low supply");

    step(2);
    #1;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule